// File: doc/BRIEF.md
# Multicore Reset and Launch Controller

This block holds sixteen 32-bit registers and controls the reset and launch of up to four processor cores. It also holds two peripheral reset bits. Software reaches the registers through a simple word-aligned write/read port. Writes to the control register are compared bit by bit with the stored value. Only the bits that differ cause an action.

A change on a core's enable bit starts a power-on or a power-off request for that core. A power-on request carries an entry address and an argument, both taken from a pair of general-purpose registers. A change on a core's reset bit starts a reset request. Each core has a one-cycle request strobe, an operation code and a completion input. The core's reset bit keeps the value that was written until the core reports completion for its outstanding request, and then it clears.

Reads are combinational on the address. Every request, and the error flag, appears one cycle after the write that caused it.

Top module: `msrc_top`

## Requirements
- R1: The register index is `reg_addr[11:2]`. The order is: 0 control, 1 boot-mode A, 2 reset status, 3 interrupt status, 4 interrupt mask, 5 boot-mode B, and 6 to 15 general-purpose registers 1 to 10 (GPR n sits at index 5+n).
- R2: After reset, control reads 0x521, reset status reads 0x1, interrupt mask reads 0x1F, and every other register reads 0.
- R3: A read returns 0 when `reg_addr[1:0]` is non-zero or when the index is 16 or more.
- R4: A write to such an address changes no register. `reg_err` is high for exactly the one cycle that follows the write edge.
- R5: A write to any index from 1 to 15 stores the data unchanged, and it reads back unchanged.
- R6: Core c (1..3) has its enable bit at bit 21+c. When that bit changes to 1, the controller gives a one-cycle `core_req[c]` with op 1 (power-on). The request carries `core_entry` = GPR(2c+1) and `core_arg` = GPR(2c+2). When the bit changes to 0, the request carries op 2 (power-off).
- R7: Core c (0..3) has its reset bit at bit 13+c. When that bit changes, the controller gives a one-cycle `core_req[c]` with op 0 (reset). If the same core's enable bit also changes in that write, the core gets only the enable request.
- R8: The reset bit of a core stores the value that was written. It clears at the first edge where `core_done[c]` is high while a request for core c is outstanding. A new request for that core in the same cycle blocks the clear. `core_done` with nothing outstanding has no effect.
- R9: A new request for a core whose earlier request is still outstanding replaces the earlier one. A single later completion then clears the reset bit.
- R10: Peripheral reset bits 3 and 12 are stored as 0 whenever a write changes them, so they always read 0.
- R11: A control write that changes none of bits 13 to 16 or 22 to 24 raises no core request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; release is synchronised inside |
| reg_wen | input | 1 | Write strobe for one cycle |
| reg_addr | input | 12 | Byte address of the access |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| reg_err | output | 1 | One-cycle flag for a write to an unmapped or misaligned address |
| core_done | input | 4 | Per-core completion |
| core_req | output | 4 | Per-core request strobe |
| core_op | output | 8 | Per-core operation code, 2 bits per core (0 reset, 1 on, 2 off) |
| core_entry | output | 128 | Per-core entry address, 32 bits per core |
| core_arg | output | 128 | Per-core argument, 32 bits per core |

## Verification
The assertions assume that every input is sampled synchronously and is never unknown after reset. They also assume that `core_done` is a level the design looks at on each edge, not a pulse the design must catch. No rule is placed on the timing of `core_done` relative to a request: completions may arrive with nothing outstanding, or in the same cycle as a fresh request. The bench changes every input one nanosecond after a rising edge and holds the inputs idle while the reset synchroniser settles. In its random phase the bench asserts `core_done` freely, so both of those unconstrained cases do occur.

// File: rtl/msrc_pkg.sv
`timescale 1ns/1ps
package msrc_pkg;
  localparam int DATA_W    = 32;
  localparam int ADDR_W    = 12;
  localparam int NUM_REGS  = 16;
  localparam int NUM_CORES = 4;
  localparam int OP_W      = 2;

  // register index map
  localparam int IDX_CTRL    = 0;
  localparam int IDX_BOOT_A  = 1;
  localparam int IDX_STAT    = 2;
  localparam int IDX_ISTAT   = 3;
  localparam int IDX_IMASK   = 4;
  localparam int IDX_BOOT_B  = 5;
  localparam int IDX_GP_BASE = 6;   // general-purpose register n lives at IDX_GP_BASE + n - 1

  // control register fields
  localparam int CORE_RST_LSB = 13;  // core c reset bit at CORE_RST_LSB + c
  localparam int CORE_EN_BASE = 21;  // core c enable bit at CORE_EN_BASE + c (c >= 1)
  localparam int PERIPH_A_BIT = 3;
  localparam int PERIPH_B_BIT = 12;

  localparam logic [DATA_W-1:0] CTRL_RST_VAL  = 32'h0000_0521;
  localparam logic [DATA_W-1:0] STAT_RST_VAL  = 32'h0000_0001;
  localparam logic [DATA_W-1:0] IMASK_RST_VAL = 32'h0000_001F;

  typedef enum logic [OP_W-1:0] {
    CORE_OP_RESET = 2'd0,
    CORE_OP_ON    = 2'd1,
    CORE_OP_OFF   = 2'd2
  } core_op_e;

  function automatic logic [DATA_W-1:0] reg_reset_value(input int idx);
    case (idx)
      IDX_CTRL:  return CTRL_RST_VAL;
      IDX_STAT:  return STAT_RST_VAL;
      IDX_IMASK: return IMASK_RST_VAL;
      default:   return '0;
    endcase
  endfunction
endpackage

// File: rtl/msrc_regfile.sv
`timescale 1ns/1ps
module msrc_regfile
  import msrc_pkg::*;
#(
  parameter int DW    = DATA_W,
  parameter int NR    = NUM_REGS,
  parameter int SEL_W = $clog2(NR)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  logic [SEL_W-1:0]       wr_idx,
  input  logic [DW-1:0]          wr_data,
  output logic [NR-1:0][DW-1:0]  regs_q
);

  // index 0 (control) is owned by msrc_ctrl; this file holds 1..NR-1
  for (genvar g = 0; g < NR; g++) begin : g_reg
    if (g == 0) begin : g_hole
      assign regs_q[g] = '0;
    end else begin : g_store
      logic          hit;
      logic [DW-1:0] val_q;
      logic [DW-1:0] val_d;

      assign hit = wr_en && (wr_idx == SEL_W'(g));

      always_comb begin
        val_d = val_q;
        if (hit) val_d = wr_data;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   val_q <= reg_reset_value(g);
        else if (hit) val_q <= val_d;
      end

      assign regs_q[g] = val_q;
    end
  end

  AST_REGS_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(regs_q)); // R5

endmodule

// File: rtl/msrc_ctrl.sv
`timescale 1ns/1ps
module msrc_ctrl
  import msrc_pkg::*;
#(
  parameter int DW      = DATA_W,
  parameter int NC      = NUM_CORES,
  parameter int RST_LSB = CORE_RST_LSB,
  parameter int EN_BASE = CORE_EN_BASE,
  parameter int PA      = PERIPH_A_BIT,
  parameter int PB      = PERIPH_B_BIT,
  parameter logic [DW-1:0] RST_VAL = CTRL_RST_VAL
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr,
  input  logic [DW-1:0]            wdata,
  input  logic [NC-1:0]            clr,
  input  logic [NC-1:0]            done,
  output logic [DW-1:0]            ctrl_q,
  output logic [NC-1:0]            evt_valid,
  output logic [NC-1:0][OP_W-1:0]  evt_op
);

  logic [DW-1:0] chg;
  logic [DW-1:0] ctrl_d;
  logic          ctrl_en;

  assign chg = ctrl_q ^ wdata;

  // per-core event decode: an enable toggle takes precedence over a reset toggle
  for (genvar c = 0; c < NC; c++) begin : g_evt
    logic en_chg;
    logic rst_chg;
    if (c == 0) begin : g_no_en
      assign en_chg = 1'b0;
    end else begin : g_en
      assign en_chg = chg[EN_BASE+c];
    end
    assign rst_chg      = chg[RST_LSB+c];
    assign evt_valid[c] = wr && (en_chg || rst_chg);

    always_comb begin
      if (en_chg) evt_op[c] = wdata[EN_BASE+c] ? CORE_OP_ON : CORE_OP_OFF;
      else        evt_op[c] = CORE_OP_RESET;
    end

    AST_RST_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_q[RST_LSB+c] && !done[c] && !wr) |=> ctrl_q[RST_LSB+c]); // R8
    AST_RST_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
      (clr[c] && !wr) |=> !ctrl_q[RST_LSB+c]); // R8
  end

  always_comb begin
    ctrl_d = ctrl_q;
    if (wr) begin
      ctrl_d = wdata;
      if (chg[PA]) ctrl_d[PA] = 1'b0;
      if (chg[PB]) ctrl_d[PB] = 1'b0;
    end
    for (int i = 0; i < NC; i++) begin
      if (clr[i]) ctrl_d[RST_LSB+i] = 1'b0;
    end
  end

  assign ctrl_en = wr || (|clr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ctrl_q <= RST_VAL;
    else if (ctrl_en) ctrl_q <= ctrl_d;
  end

  AST_PERIPH_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    wr |=> (!ctrl_q[PA] && !ctrl_q[PB])); // R10

endmodule

// File: rtl/msrc_core_port.sv
`timescale 1ns/1ps
module msrc_core_port
  import msrc_pkg::*;
#(
  parameter int DW = DATA_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          evt_valid,
  input  core_op_e      evt_op,
  input  logic [DW-1:0] evt_entry,
  input  logic [DW-1:0] evt_arg,
  input  logic          done,
  output logic          req,
  output core_op_e      op,
  output logic [DW-1:0] entry,
  output logic [DW-1:0] arg,
  output logic          clr
);

  logic          pend_q, pend_d;
  logic          req_q, req_d;
  core_op_e      op_q, op_d;
  logic [DW-1:0] entry_q, entry_d;
  logic [DW-1:0] arg_q, arg_d;

  always_comb begin
    pend_d  = pend_q;
    req_d   = evt_valid;
    op_d    = op_q;
    entry_d = entry_q;
    arg_d   = arg_q;
    if (evt_valid) begin
      pend_d  = 1'b1;
      op_d    = evt_op;
      entry_d = evt_entry;
      arg_d   = evt_arg;
    end else if (done && pend_q) begin
      pend_d  = 1'b0;
    end
  end

  assign clr = done && pend_q && !evt_valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q  <= 1'b0;
      req_q   <= 1'b0;
      op_q    <= CORE_OP_RESET;
      entry_q <= '0;
      arg_q   <= '0;
    end else begin
      pend_q <= pend_d;
      req_q  <= req_d;
      if (evt_valid) begin
        op_q    <= op_d;
        entry_q <= entry_d;
        arg_q   <= arg_d;
      end
    end
  end

  assign req   = req_q;
  assign op    = op_q;
  assign entry = entry_q;
  assign arg   = arg_q;

  AST_LAUNCH_PENDS: assert property (@(posedge clk) disable iff (!rst_n)
    evt_valid |=> (req && pend_q)); // R9
  AST_IDLE_DONE_NOP: assert property (@(posedge clk) disable iff (!rst_n)
    (!pend_q && !evt_valid) |=> !pend_q); // R8

endmodule

// File: rtl/msrc_top.sv
`timescale 1ns/1ps
module msrc_top
  import msrc_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int AW = ADDR_W,
  parameter int NR = NUM_REGS,
  parameter int NC = NUM_CORES
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wen,
  input  logic [AW-1:0]    reg_addr,
  input  logic [DW-1:0]    reg_wdata,
  output logic [DW-1:0]    reg_rdata,
  output logic             reg_err,
  input  logic [NC-1:0]    core_done,
  output logic [NC-1:0]    core_req,
  output logic [NC*OP_W-1:0] core_op,
  output logic [NC*DW-1:0] core_entry,
  output logic [NC*DW-1:0] core_arg
);

  localparam int IDX_W = AW - 2;
  localparam int SEL_W = $clog2(NR);
  localparam logic [IDX_W-1:0] NR_IDX = IDX_W'(NR);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rs_q;
  logic       rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= '0;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_sync_n = rs_q[1];

  // address decode
  logic [IDX_W-1:0] idx;
  logic             aligned, hit, ctrl_wr, gen_wr, bad_wr;

  assign idx     = reg_addr[AW-1:2];
  assign aligned = (reg_addr[1:0] == 2'b00);
  assign hit     = aligned && (idx < NR_IDX);
  assign ctrl_wr = reg_wen && hit && (idx == IDX_W'(IDX_CTRL));
  assign gen_wr  = reg_wen && hit && (idx != IDX_W'(IDX_CTRL));
  assign bad_wr  = reg_wen && !hit;

  logic [NR-1:0][DW-1:0]  regs_q;
  logic [DW-1:0]          ctrl_q;
  logic [NC-1:0]          evt_valid;
  logic [NC-1:0][OP_W-1:0] evt_op;
  logic [NC-1:0]          clr;

  msrc_regfile #(.DW(DW), .NR(NR), .SEL_W(SEL_W)) u_regs (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .wr_en   (gen_wr),
    .wr_idx  (idx[SEL_W-1:0]),
    .wr_data (reg_wdata),
    .regs_q  (regs_q)
  );

  msrc_ctrl #(.DW(DW), .NC(NC)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .wr        (ctrl_wr),
    .wdata     (reg_wdata),
    .clr       (clr),
    .done      (core_done),
    .ctrl_q    (ctrl_q),
    .evt_valid (evt_valid),
    .evt_op    (evt_op)
  );

  for (genvar c = 0; c < NC; c++) begin : g_core
    logic [DW-1:0] ent_src, arg_src, ent_c, arg_c;
    core_op_e      op_c;

    if (c == 0) begin : g_no_launch
      assign ent_src = '0;
      assign arg_src = '0;
    end else begin : g_launch
      assign ent_src = regs_q[IDX_GP_BASE + 2*c];
      assign arg_src = regs_q[IDX_GP_BASE + 2*c + 1];
    end

    msrc_core_port #(.DW(DW)) u_port (
      .clk       (clk),
      .rst_n     (rst_sync_n),
      .evt_valid (evt_valid[c]),
      .evt_op    (core_op_e'(evt_op[c])),
      .evt_entry (ent_src),
      .evt_arg   (arg_src),
      .done      (core_done[c]),
      .req       (core_req[c]),
      .op        (op_c),
      .entry     (ent_c),
      .arg       (arg_c),
      .clr       (clr[c])
    );

    assign core_op[c*OP_W +: OP_W] = op_c;
    assign core_entry[c*DW +: DW]  = ent_c;
    assign core_arg[c*DW +: DW]    = arg_c;

    AST_REQ_AFTER_CTRL_WRITE: assert property (@(posedge clk) disable iff (!rst_sync_n)
      core_req[c] |-> $past(ctrl_wr)); // R6
  end

  // read path
  always_comb begin
    reg_rdata = '0;
    if (hit) begin
      if (idx == IDX_W'(IDX_CTRL)) reg_rdata = ctrl_q;
      else                         reg_rdata = regs_q[idx[SEL_W-1:0]];
    end
  end

  // error flag
  logic err_q, err_d;
  assign err_d = bad_wr;
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) err_q <= 1'b0;
    else             err_q <= err_d;
  end
  assign reg_err = err_q;

  AST_BAD_WRITE_FLAGGED: assert property (@(posedge clk) disable iff (!rst_sync_n)
    bad_wr |=> reg_err); // R4
  AST_ERR_NEEDS_BAD_WRITE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    reg_err |-> $past(bad_wr)); // R4
  AST_BAD_WRITE_KEEPS_CTRL: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (bad_wr && !(|clr)) |=> $stable(ctrl_q)); // R4

endmodule

// File: tb/msrc_top_test.sv
`timescale 1ns/1ps
module msrc_top_test;
  logic         clk = 1'b0;
  logic         rst_n;
  logic         reg_wen;
  logic [11:0]  reg_addr;
  logic [31:0]  reg_wdata;
  logic [31:0]  reg_rdata;
  logic         reg_err;
  logic [3:0]   core_done;
  logic [3:0]   core_req;
  logic [7:0]   core_op;
  logic [127:0] core_entry;
  logic [127:0] core_arg;

  always #2.5 clk = ~clk;

  msrc_top uut (
    .clk(clk), .rst_n(rst_n), .reg_wen(reg_wen), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .reg_err(reg_err),
    .core_done(core_done), .core_req(core_req), .core_op(core_op),
    .core_entry(core_entry), .core_arg(core_arg)
  );

  int n_chk = 0;
  int n_fail = 0;
  int cycles = 0;
  bit go = 1'b0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // ---------------- behavioural reference ----------------
  logic [31:0] m_reg [16];
  bit          m_pend [4];
  bit   [3:0]  m_req;
  int          m_op [4];
  logic [31:0] m_ent [4];
  logic [31:0] m_arg [4];
  bit          m_err;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 16; i++) m_reg[i] = 32'h0;
      m_reg[0] = 32'h521; m_reg[2] = 32'h1; m_reg[4] = 32'h1F;
      for (int c = 0; c < 4; c++) begin
        m_pend[c] = 0; m_op[c] = 0; m_ent[c] = 0; m_arg[c] = 0;
      end
      m_req = 0; m_err = 0;
    end else begin
      automatic int          ix  = int'(reg_addr >> 2);
      automatic bit          ok  = (reg_addr[1:0] == 2'b00) && (ix < 16);
      automatic logic [31:0] old = m_reg[0];
      automatic logic [31:0] nv  = old;
      automatic logic [31:0] ch;
      automatic bit   [3:0]  ev  = 0;
      m_err = reg_wen && !ok;
      m_req = 0;
      if (reg_wen && ok && ix != 0) m_reg[ix] = reg_wdata;
      if (reg_wen && ok && ix == 0) begin
        ch = old ^ reg_wdata;
        nv = reg_wdata;
        if (ch[3])  nv[3]  = 1'b0;
        if (ch[12]) nv[12] = 1'b0;
        for (int c = 0; c < 4; c++) begin
          if (c > 0 && ch[21+c]) begin
            ev[c] = 1; m_op[c] = reg_wdata[21+c] ? 1 : 2;
          end else if (ch[13+c]) begin
            ev[c] = 1; m_op[c] = 0;
          end
          if (ev[c]) begin
            m_ent[c] = (c == 0) ? 32'h0 : m_reg[6+2*c];
            m_arg[c] = (c == 0) ? 32'h0 : m_reg[7+2*c];
          end
        end
      end
      for (int c = 0; c < 4; c++) begin
        if (ev[c]) begin
          m_pend[c] = 1; m_req[c] = 1;
        end else if (core_done[c] && m_pend[c]) begin
          m_pend[c] = 0; nv[13+c] = 1'b0;
        end
      end
      m_reg[0] = nv;
    end
  end

  // per-cycle comparison, away from the rising edge
  always @(negedge clk) begin
    if (go) begin
      automatic int ix = int'(reg_addr >> 2);
      automatic bit ok = (reg_addr[1:0] == 2'b00) && (ix < 16);
      if (!ok)          chk("R3 unmapped read", reg_rdata, 32'h0);
      else if (ix == 0) chk("R8 control readback", reg_rdata, m_reg[0]);
      else              chk("R1/R5 register readback", reg_rdata, m_reg[ix]);
      chk("R4 error flag", 32'(reg_err), 32'(m_err));
      chk("R6/R7 request vector", 32'(core_req), 32'(m_req));
      for (int c = 0; c < 4; c++) begin
        if (m_req[c]) begin
          chk("R6/R7 op code", 32'(core_op[c*2 +: 2]), 32'(m_op[c]));
          if (m_op[c] == 1) begin
            chk("R6 entry", core_entry[c*32 +: 32], m_ent[c]);
            chk("R6 argument", core_arg[c*32 +: 32], m_arg[c]);
          end
        end
      end
    end
  end

  // watchdog
  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      n_fail++;
      $display("FAIL watchdog expired after %0d cycles", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  // ---------------- stimulus ----------------
  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    reg_wen = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #1;
    reg_wen = 1'b0;
  endtask

  task automatic rd_chk(input logic [11:0] a, input logic [31:0] exp, input string tag);
    @(posedge clk); #1;
    reg_addr = a;
    @(negedge clk);
    chk(tag, reg_rdata, exp);
  endtask

  task automatic pulse_done(input logic [3:0] m);
    @(posedge clk); #1 core_done = m;
    @(posedge clk); #1 core_done = 4'b0;
  endtask

  function automatic logic [31:0] gv(input int n);
    return 32'h0A00_0000 | 32'(n << 12) | 32'(n * 3);
  endfunction

  initial begin
    rst_n = 1'b0; reg_wen = 1'b0; reg_addr = '0; reg_wdata = '0; core_done = '0;
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);
    go = 1'b1;

    // R2 reset values
    for (int i = 0; i < 16; i++)
      rd_chk(12'(i*4), (i == 0) ? 32'h521 : (i == 2) ? 32'h1 : (i == 4) ? 32'h1F : 32'h0, "R2 reset value");

    // R1 / R5 general-purpose and other registers
    for (int n = 1; n <= 10; n++) wr(12'((5+n)*4), gv(n));
    for (int n = 1; n <= 10; n++) rd_chk(12'((5+n)*4), gv(n), "R1 gpr placement");
    wr(12'h00C, 32'hDEAD_BEEF);
    rd_chk(12'h00C, 32'hDEAD_BEEF, "R5 interrupt status store");

    // R6 power-on of core 1 with its reset bit set
    wr(12'h000, 32'h0040_4521);
    chk("R6 on request", 32'(core_req), 32'h2);
    chk("R6 on op", 32'(core_op[3:2]), 32'h1);
    chk("R6 entry from GPR3", core_entry[63:32], gv(3));
    chk("R6 arg from GPR4", core_arg[63:32], gv(4));
    rd_chk(12'h000, 32'h0040_4521, "R8 bit held until done");
    pulse_done(4'b0010);
    rd_chk(12'h000, 32'h0040_0521, "R8 cleared by done");

    // R7 reset of core 0; done on an idle core does nothing
    wr(12'h000, 32'h0040_2521);
    chk("R7 reset request", 32'(core_req), 32'h1);
    chk("R7 reset op", 32'(core_op[1:0]), 32'h0);
    pulse_done(4'b0100);
    rd_chk(12'h000, 32'h0040_2521, "R8 idle done ignored");

    // R9 replacement while pending
    wr(12'h000, 32'h0040_0521);
    chk("R9 second request", 32'(core_req), 32'h1);
    wr(12'h000, 32'h0040_2521);
    chk("R9 third request", 32'(core_req), 32'h1);
    pulse_done(4'b0001);
    rd_chk(12'h000, 32'h0040_0521, "R9 single done clears");

    // R6 power-off of core 1
    wr(12'h000, 32'h0000_0521);
    chk("R6 off request", 32'(core_req), 32'h2);
    chk("R6 off op", 32'(core_op[3:2]), 32'h2);
    pulse_done(4'b0010);

    // R10 peripheral bits read as zero
    wr(12'h000, 32'h0000_1529);
    chk("R10 no core request", 32'(core_req), 32'h0);
    rd_chk(12'h000, 32'h0000_0521, "R10 peripheral bits zero");

    // R11 unchanged write
    wr(12'h000, 32'h0000_0521);
    chk("R11 no request", 32'(core_req), 32'h0);

    // R6 cores 2 and 3 together
    wr(12'h000, 32'h0180_0521);
    chk("R6 dual request", 32'(core_req), 32'hC);
    chk("R6 core2 entry GPR5", core_entry[95:64], gv(5));
    chk("R6 core3 arg GPR8", core_arg[127:96], gv(8));

    // R4 bad writes
    wr(12'h040, 32'hFFFF_FFFF);
    chk("R4 flag out of range", 32'(reg_err), 32'h1);
    @(posedge clk); #1;
    chk("R4 flag lasts one cycle", 32'(reg_err), 32'h0);
    wr(12'h002, 32'h0);
    chk("R4 flag misaligned", 32'(reg_err), 32'h1);
    rd_chk(12'h000, 32'h0180_0521, "R4 control untouched");
    wr(12'hFFC, 32'h1234_5678);
    chk("R4 flag top of window", 32'(reg_err), 32'h1);

    // R3 unmapped reads
    rd_chk(12'h040, 32'h0, "R3 out of range read");
    rd_chk(12'h021, 32'h0, "R3 misaligned read");
    rd_chk(12'hFFC, 32'h0, "R3 window end read");
    pulse_done(4'b1100);

    // mixed random traffic, compared every cycle
    for (int k = 0; k < 800; k++) begin
      automatic int r = int'($urandom % 8);
      @(posedge clk); #1;
      core_done = 4'($urandom);
      reg_wen = 1'b0;
      reg_addr = 12'(($urandom % 16) * 4);
      if (r < 3) begin
        reg_wen = 1'b1; reg_addr = 12'h000;
        reg_wdata = m_reg[0] ^ ($urandom & 32'h01C1_F008);
      end else if (r == 3) begin
        reg_wen = 1'b1; reg_addr = 12'((6 + $urandom % 10) * 4);
        reg_wdata = $urandom;
      end else if (r == 4) begin
        reg_wen = 1'b1; reg_wdata = $urandom;
        reg_addr = (($urandom % 2) == 0) ? (12'($urandom) | 12'h040) : (12'($urandom) | 12'h001);
      end
    end
    @(posedge clk); #1;
    reg_wen = 1'b0; core_done = 4'b0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    go = 1'b0;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule